// File: doc/BRIEF.md
# Pixel Array Configuration Shift Chain

This block holds the static settings of a pixel readout matrix of `NUM_COLS` columns with `CH_PER_COL` channels each. By default the matrix is 24 by 64, which gives 1536 channels. The settings arrive through two independent serial chains, each with its own data input and shift enable, on a common clock.

The channel chain carries one 14-bit word per channel. The channels are linked end to end, so the default chain is 21504 bits long. The column chain carries one 2-bit word per column, 48 bits by default.

While data shifts, the control outputs keep their previous values, because they come from shadow copies of the chains. A single-cycle load strobe copies both chains into their shadows at once.

Each channel word is split into named fields:
- a threshold-trim code, made of a range bit and a 4-bit current-source enable,
- a 4-bit gain select,
- a discriminator mask bit,
- three probe enables,
- a test-injection enable.

The column word gives the column's power state and says whether the column is the one routed to the probes. A channel's probe and test-injection outputs are forced low unless its column is both powered and probe-selected.

The last bit of each chain appears on that chain's serial output. Shifting a new image in therefore reads the old one back out.

Top module: `pixel_cfg_chain`

## Requirements
- R1: While `rst_n` is low at a rising edge, every chain bit and every shadow bit is cleared. After that edge all control outputs and both serial outputs are 0.
- R2: On a rising edge with `ch_shift` high, `ch_sin` enters chain bit 0 and every bit moves up one place. `ch_sout` shows chain bit `14*NUM_COLS*CH_PER_COL-1`, so a bit shifted in reappears at `ch_sout` after that many shifts.
- R3: The column chain follows the same rule with `col_shift`, `col_sin` and `col_sout`, over `2*NUM_COLS` bits.
- R4: Between load strobes, all control outputs hold their values, including while either chain shifts.
- R5: On a rising edge with `load` high, both shadows take the chain contents as they stood before that edge, even when a shift happens on the same edge.
- R6: Channel k occupies chain bits [14k+13:14k] and belongs to column k / `CH_PER_COL`. Within the word:
  - bit 0 is the discriminator mask,
  - bits 4:1 are the gain select,
  - bits 9:5 are the threshold code,
  - bit 10 is the discriminator probe,
  - bit 11 is the shaper probe,
  - bit 12 is the preamplifier probe,
  - bit 13 is the test-injection enable.
- R7: The threshold code is exposed in two parts. Its top bit (word bit 9) drives `thr_range`, and its low four bits (word bits 8:5) drive `thr_isrc`.
- R8: Column c occupies column-chain bits [2c+1:2c]. Bit 2c drives `col_power[c]` and bit 2c+1 drives `col_probe_sel[c]`.
- R9: The test-injection and the three probe outputs of a channel equal their word bits only when its column's power bit and probe-select bit are both 1; otherwise they are 0. Mask, gain and threshold outputs do not depend on the column word.
- R10: With its shift enable low, a chain keeps its contents and its serial output stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift and load clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_shift | input | 1 | Shift enable of the channel chain |
| ch_sin | input | 1 | Serial data into the channel chain |
| ch_sout | output | 1 | Last bit of the channel chain |
| col_shift | input | 1 | Shift enable of the column chain |
| col_sin | input | 1 | Serial data into the column chain |
| col_sout | output | 1 | Last bit of the column chain |
| load | input | 1 | One-cycle strobe copying both chains to their shadows |
| test_inj | output | NUM_COLS*CH_PER_COL | Gated test-injection enable per channel |
| probe_pre | output | NUM_COLS*CH_PER_COL | Gated preamplifier probe enable per channel |
| probe_shp | output | NUM_COLS*CH_PER_COL | Gated shaper probe enable per channel |
| probe_disc | output | NUM_COLS*CH_PER_COL | Gated discriminator probe enable per channel |
| thr_range | output | NUM_COLS*CH_PER_COL | Threshold load-range select per channel |
| thr_isrc | output | 4*NUM_COLS*CH_PER_COL | Threshold current-source enables, 4 per channel |
| gain_sel | output | 4*NUM_COLS*CH_PER_COL | Gain select, 4 per channel |
| disc_mask | output | NUM_COLS*CH_PER_COL | Discriminator mask per channel |
| col_power | output | NUM_COLS | Column power enable |
| col_probe_sel | output | NUM_COLS | Column routed to the probes |

## Verification
The bench builds the block with `NUM_COLS = 3` and `CH_PER_COL = 2`. That gives an 84-bit channel chain and a 6-bit column chain.

At this size, every serial bit of every readback can be compared, and all 64 combinations of the three column words can be swept against a channel image with every field set. This exercises the gating of every channel under every power and probe-select pairing.

Three columns are enough to place a channel at both the start and the end of a column boundary. This catches errors in the channel-to-column index. A load issued on the same edge as a shift is also driven, to show which contents the shadows capture.

// File: rtl/pxcfg_pkg.sv
// Shared field layout of the channel and column configuration words.
// Assumes the word layout below is fixed; only the array size is a parameter.
package pxcfg_pkg;
    localparam int CH_W     = 14;  // bits per channel word
    localparam int COL_W    = 2;   // bits per column word
    localparam int THR_W    = 5;   // threshold code width
    localparam int ISRC_W   = THR_W - 1;
    localparam int GAIN_W   = 4;
    localparam int COL_PWR  = 0;   // bit within column word
    localparam int COL_PRB  = 1;

    // First member is the MSB: word bit 13 down to bit 0.
    typedef struct packed {
        logic              test_en;
        logic              pr_pre;
        logic              pr_shp;
        logic              pr_disc;
        logic [THR_W-1:0]  thr;
        logic [GAIN_W-1:0] gain;
        logic              mask;
    } chan_word_t;
endpackage

// File: rtl/pxcfg_shift_chain.sv
// One serial chain with a shadow copy.
// Shifts toward the MSB on enabled edges; the shadow is updated only by the load strobe.
// Assumes LEN >= 2.
module pxcfg_shift_chain #(
    parameter int LEN = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           shift_en,
    input  logic           sin,
    input  logic           load,
    output logic           sout,
    output logic [LEN-1:0] image
);
    logic [LEN-1:0] chain_q;

    // Serial shift register: the new bit enters at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain_q <= '0;
        else if (shift_en)
            chain_q <= {chain_q[LEN-2:0], sin};
    end

    // Shadow copy taken from the pre-edge chain contents on load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            image <= '0;
        else if (load)
            image <= chain_q;
    end

    assign sout = chain_q[LEN-1];
endmodule

// File: rtl/pxcfg_chan_decode.sv
// Splits one channel word into its control fields.
// Gates the probe and test-injection outputs with the column's power and probe-select bits.
// Purely combinational.
module pxcfg_chan_decode
    import pxcfg_pkg::*;
(
    input  logic [CH_W-1:0]   word,
    input  logic              col_on,
    input  logic              col_pick,
    output logic              test_inj,
    output logic              probe_pre,
    output logic              probe_shp,
    output logic              probe_disc,
    output logic              thr_range,
    output logic [ISRC_W-1:0] thr_isrc,
    output logic [GAIN_W-1:0] gain_sel,
    output logic              disc_mask
);
    chan_word_t w;
    logic       route_ok;

    // Field extraction and column gating.
    always_comb begin
        w          = chan_word_t'(word);
        route_ok   = col_on & col_pick;
        test_inj   = w.test_en & route_ok;
        probe_pre  = w.pr_pre  & route_ok;
        probe_shp  = w.pr_shp  & route_ok;
        probe_disc = w.pr_disc & route_ok;
        thr_range  = w.thr[THR_W-1];
        thr_isrc   = w.thr[ISRC_W-1:0];
        gain_sel   = w.gain;
        disc_mask  = w.mask;
    end
endmodule

// File: rtl/pixel_cfg_chain.sv
// Top level of the pixel array configuration: a channel chain, a column chain,
// and one decoder per channel.
// Assumes the load strobe is a single-cycle pulse issued after shifting ends.
module pixel_cfg_chain
    import pxcfg_pkg::*;
#(
    parameter int NUM_COLS   = 24,
    parameter int CH_PER_COL = 64
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   ch_shift,
    input  logic                                   ch_sin,
    output logic                                   ch_sout,
    input  logic                                   col_shift,
    input  logic                                   col_sin,
    output logic                                   col_sout,
    input  logic                                   load,
    output logic [NUM_COLS*CH_PER_COL-1:0]         test_inj,
    output logic [NUM_COLS*CH_PER_COL-1:0]         probe_pre,
    output logic [NUM_COLS*CH_PER_COL-1:0]         probe_shp,
    output logic [NUM_COLS*CH_PER_COL-1:0]         probe_disc,
    output logic [NUM_COLS*CH_PER_COL-1:0]         thr_range,
    output logic [4*NUM_COLS*CH_PER_COL-1:0]       thr_isrc,
    output logic [4*NUM_COLS*CH_PER_COL-1:0]       gain_sel,
    output logic [NUM_COLS*CH_PER_COL-1:0]         disc_mask,
    output logic [NUM_COLS-1:0]                    col_power,
    output logic [NUM_COLS-1:0]                    col_probe_sel
);
    localparam int N_CH    = NUM_COLS * CH_PER_COL;
    localparam int CH_LEN  = N_CH * CH_W;
    localparam int COL_LEN = NUM_COLS * COL_W;

    logic [CH_LEN-1:0]  ch_image;
    logic [COL_LEN-1:0] col_image;

    pxcfg_shift_chain #(.LEN(CH_LEN)) u_ch_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (ch_shift),
        .sin      (ch_sin),
        .load     (load),
        .sout     (ch_sout),
        .image    (ch_image)
    );

    pxcfg_shift_chain #(.LEN(COL_LEN)) u_col_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (col_shift),
        .sin      (col_sin),
        .load     (load),
        .sout     (col_sout),
        .image    (col_image)
    );

    // Column word fan-out.
    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
        assign col_power[c]     = col_image[c*COL_W + COL_PWR];
        assign col_probe_sel[c] = col_image[c*COL_W + COL_PRB];
    end

    // One decoder per channel, gated by the column that channel belongs to.
    for (genvar k = 0; k < N_CH; k++) begin : g_ch
        localparam int COL = k / CH_PER_COL;
        pxcfg_chan_decode u_dec (
            .word       (ch_image[k*CH_W +: CH_W]),
            .col_on     (col_image[COL*COL_W + COL_PWR]),
            .col_pick   (col_image[COL*COL_W + COL_PRB]),
            .test_inj   (test_inj[k]),
            .probe_pre  (probe_pre[k]),
            .probe_shp  (probe_shp[k]),
            .probe_disc (probe_disc[k]),
            .thr_range  (thr_range[k]),
            .thr_isrc   (thr_isrc[k*ISRC_W +: ISRC_W]),
            .gain_sel   (gain_sel[k*GAIN_W +: GAIN_W]),
            .disc_mask  (disc_mask[k])
        );
    end
endmodule

// File: rtl/pxcfg_chain_checker.sv
// Assertion checker for pixel_cfg_chain, attached with the bind statement at the end of this file.
module pxcfg_chain_checker #(
    parameter int NUM_COLS   = 24,
    parameter int CH_PER_COL = 64
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             ch_shift,
    input logic                             ch_sout,
    input logic                             col_shift,
    input logic                             col_sout,
    input logic                             load,
    input logic [NUM_COLS*CH_PER_COL-1:0]   test_inj,
    input logic [NUM_COLS*CH_PER_COL-1:0]   probe_pre,
    input logic [NUM_COLS*CH_PER_COL-1:0]   probe_shp,
    input logic [NUM_COLS*CH_PER_COL-1:0]   probe_disc,
    input logic [NUM_COLS*CH_PER_COL-1:0]   thr_range,
    input logic [4*NUM_COLS*CH_PER_COL-1:0] thr_isrc,
    input logic [4*NUM_COLS*CH_PER_COL-1:0] gain_sel,
    input logic [NUM_COLS*CH_PER_COL-1:0]   disc_mask,
    input logic [NUM_COLS-1:0]              col_power,
    input logic [NUM_COLS-1:0]              col_probe_sel
);
    localparam int N_CH = NUM_COLS * CH_PER_COL;

    logic [N_CH-1:0] routed;
    logic            gate_err;

    // Which channels the column outputs allow to drive probes or injection.
    always_comb begin
        for (int k = 0; k < N_CH; k++)
            routed[k] = col_power[k / CH_PER_COL] & col_probe_sel[k / CH_PER_COL];
        gate_err = |((test_inj | probe_pre | probe_shp | probe_disc) & ~routed);
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable({test_inj, probe_pre, probe_shp, probe_disc, thr_range,
                           thr_isrc, gain_sel, disc_mask, col_power, col_probe_sel})); // R4

    AST_PROBE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_err); // R9

    AST_CH_SOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_shift |=> $stable(ch_sout)); // R10

    AST_COL_SOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !col_shift |=> $stable(col_sout)); // R10
endmodule

bind pixel_cfg_chain pxcfg_chain_checker #(
    .NUM_COLS   (NUM_COLS),
    .CH_PER_COL (CH_PER_COL)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ch_shift      (ch_shift),
    .ch_sout       (ch_sout),
    .col_shift     (col_shift),
    .col_sout      (col_sout),
    .load          (load),
    .test_inj      (test_inj),
    .probe_pre     (probe_pre),
    .probe_shp     (probe_shp),
    .probe_disc    (probe_disc),
    .thr_range     (thr_range),
    .thr_isrc      (thr_isrc),
    .gain_sel      (gain_sel),
    .disc_mask     (disc_mask),
    .col_power     (col_power),
    .col_probe_sel (col_probe_sel)
);

// File: tb/tb_pixel_cfg_chain.sv
`timescale 1ns/1ps
// Bench for pixel_cfg_chain in a 3x2 configuration.
// Inputs change and outputs are sampled on falling edges.
module tb_pixel_cfg_chain;
    localparam int NC   = 3;
    localparam int CPC  = 2;
    localparam int N    = NC * CPC;
    localparam int CL   = N * 14;
    localparam int KL   = NC * 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ch_shift = 1'b0, ch_sin = 1'b0, col_shift = 1'b0, col_sin = 1'b0, load = 1'b0;
    logic ch_sout, col_sout;
    logic [N-1:0]   test_inj, probe_pre, probe_shp, probe_disc, thr_range, disc_mask;
    logic [4*N-1:0] thr_isrc, gain_sel;
    logic [NC-1:0]  col_power, col_probe_sel;

    int unsigned vectors = 0, errors = 0, seed = 32'h1234_5678;
    logic [CL-1:0] chm = '0, exp_ch = '0, img;   // chain model, expected shadow
    logic [KL-1:0] colm = '0, exp_col = '0, kimg;

    always #10 clk = ~clk;  // 50 MHz

    pixel_cfg_chain #(.NUM_COLS(NC), .CH_PER_COL(CPC)) dut (
        .clk(clk), .rst_n(rst_n), .ch_shift(ch_shift), .ch_sin(ch_sin), .ch_sout(ch_sout),
        .col_shift(col_shift), .col_sin(col_sin), .col_sout(col_sout), .load(load),
        .test_inj(test_inj), .probe_pre(probe_pre), .probe_shp(probe_shp),
        .probe_disc(probe_disc), .thr_range(thr_range), .thr_isrc(thr_isrc),
        .gain_sel(gain_sel), .disc_mask(disc_mask), .col_power(col_power),
        .col_probe_sel(col_probe_sel)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h @%0t", req, act, exp, $time);
        end
    endtask

    task automatic next_rand(output logic [31:0] r);
        seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
        r = seed;
    endtask

    // One clock: drive at the current falling edge, update the models at the rising edge.
    task automatic step(input logic cs, input logic cb, input logic ks, input logic kb, input logic ld);
        ch_shift = cs; ch_sin = cb; col_shift = ks; col_sin = kb; load = ld;
        @(posedge clk);
        if (ld) begin exp_ch = chm; exp_col = colm; end
        if (cs) chm = {chm[CL-2:0], cb};
        if (ks) colm = {colm[KL-2:0], kb};
        @(negedge clk);
        ch_shift = 0; col_shift = 0; load = 0;
    endtask

    // Every control output against the expected shadows: R6 R7 R8 R9.
    task automatic check_outputs(input string tag);
        for (int c = 0; c < NC; c++)
            chk({col_probe_sel[c], col_power[c]} == exp_col[c*2 +: 2],
                {"R8 col word ", tag}, {col_probe_sel[c], col_power[c]}, exp_col[c*2 +: 2]);
        for (int k = 0; k < N; k++) begin
            logic [13:0] w, e, a;
            logic        en;
            w  = exp_ch[k*14 +: 14];
            en = exp_col[(k/CPC)*2] & exp_col[(k/CPC)*2 + 1];
            e  = {w[13] & en, w[12] & en, w[11] & en, w[10] & en, w[9:0]};
            a  = {test_inj[k], probe_pre[k], probe_shp[k], probe_disc[k], thr_range[k],
                  thr_isrc[k*4 +: 4], gain_sel[k*4 +: 4], disc_mask[k]};
            chk(a == e, {"R6 R7 R9 channel fields ", tag}, a, e);
        end
    endtask

    // Shift full images into both chains while reading the old contents back: R2 R3.
    task automatic shift_images(input logic [CL-1:0] ci, input logic [KL-1:0] ki);
        for (int j = 0; j < CL; j++) begin
            chk(ch_sout === chm[CL-1], "R2 channel readback", ch_sout, chm[CL-1]);
            if (j < KL)
                chk(col_sout === colm[KL-1], "R3 column readback", col_sout, colm[KL-1]);
            step(1'b1, ci[CL-1-j], j < KL, (j < KL) ? ki[KL-1-j] : 1'b0, 1'b0);
        end
    endtask

    initial begin : watchdog
        #(20ns * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check_outputs("R1 after reset");
        chk(ch_sout === 1'b0 && col_sout === 1'b0, "R1 serial outputs", {ch_sout, col_sout}, 0);

        // Pseudo-random images; the first uses every column fully routed.
        for (int p = 0; p < 5; p++) begin
            for (int b = 0; b < CL; b += 32) begin
                next_rand(r);
                for (int i = 0; i < 32 && b + i < CL; i++) img[b+i] = r[i];
            end
            next_rand(r);
            kimg = (p == 0) ? '1 : r[KL-1:0];
            shift_images(img, kimg);
            check_outputs("R4 held while shifting");
            step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
            check_outputs("R5 after load");
        end

        // R10: enables low, chains and serial outputs hold.
        for (int j = 0; j < 5; j++) begin
            step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
            chk(ch_sout === chm[CL-1] && col_sout === colm[KL-1], "R10 hold",
                {ch_sout, col_sout}, {chm[CL-1], colm[KL-1]});
        end

        // R9: all channel fields set, sweep every column word combination.
        shift_images('1, '0);
        for (int m = 0; m < (1 << KL); m++) begin
            for (int j = 0; j < KL; j++) begin
                logic [KL-1:0] mv;
                mv = m[KL-1:0];
                step(1'b0, 1'b0, 1'b1, mv[KL-1-j], 1'b0);
            end
            step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
            check_outputs("R9 gating sweep");
        end

        // R5: load on the same edge as a shift captures the pre-shift contents.
        shift_images({CL/2{2'b10}}, {KL/2{2'b11}});
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        chk(exp_ch == {CL/2{2'b10}}, "R5 model capture", 0, 0);
        check_outputs("R5 load with shift");
        // The shifted chain must still read back after the shared edge.
        chk(ch_sout === chm[CL-1], "R2 after load-shift", ch_sout, chm[CL-1]);

        // R1 again: reset clears a loaded state.
        rst_n = 1'b0;
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chm = '0; colm = '0; exp_ch = '0; exp_col = '0;
        check_outputs("R1 second reset");
        chk(ch_sout === 1'b0 && col_sout === 1'b0, "R1 serial after reset", {ch_sout, col_sout}, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule